// File: doc/BRIEF.md
# Prefetch-Tracking Direct-Mapped Tag Store

This block holds the tags of an 8 KB direct-mapped L1 data cache with 32-byte lines. That gives 256 lines, an 8-bit set index taken from address bits [12:5] and a 19-bit tag taken from bits [31:13]. A demand load or store presents its address and learns in the same cycle whether the line is resident. Line fills arrive on a separate port. Each fill is marked as either a demand-miss fill or a prefetch fill, and a prefetch fill carries the program counter of the instruction that triggered it.

Every line keeps three extra facts:
- a "came from prefetch" flag,
- a "touched by demand" flag,
- the trigger PC.

When a fill displaces a line that came from a prefetch, the block emits a one-cycle eviction record. The record says whether that prefetch was useful, and a pollution filter downstream learns from it. The filter can key on the line address or on the trigger PC; both are in the record.

Top module: `pf_tag_store`

## Requirements
- R1: While `dm_valid_i` is high, `dm_hit_o` is high in the same cycle exactly when the indexed line is valid and its stored tag equals `dm_addr_i[31:13]`, and `dm_miss_o` is high otherwise. Both outputs are low while `dm_valid_i` is low.
- R2: After reset is asserted, every line is invalid and carries no prefetch or reference mark, so every demand access misses, and `ev_valid_o` is low.
- R3: A demand-miss fill (`fill_is_pf_i`=0) makes the line valid with the new tag and clears both the prefetch mark and the reference mark. Displacing such a line later produces no record.
- R4: A prefetch fill (`fill_is_pf_i`=1) to a line that is invalid or holds another tag stores the new tag, sets the prefetch mark, clears the reference mark and captures `fill_pc_i`.
- R5: A demand hit sets the reference mark of the line it hit.
- R6: When a fill replaces a valid line that holds a different tag and has its prefetch mark set, `ev_valid_o` is high in the cycle after the fill edge. In that cycle, `ev_addr_o` = {old tag, index, 5'b0}, `ev_pc_o` is the stored trigger PC, and `ev_good_o` equals the old reference mark.
- R7: No record is produced when the replaced line was invalid or had its prefetch mark clear. No record is produced when a demand fill lands on a valid line with the same tag; that fill clears both marks.
- R8: A prefetch fill to a valid line with the same tag is ignored. The marks and the PC are unchanged.
- R9: A demand hit on a line in the same cycle as a fill that replaces it counts as a use (`ev_good_o`=1). The reference mark is not carried over to the new line.
- R10: `ev_valid_o` is a single-cycle pulse and is never high in a cycle that does not follow a fill edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dm_valid_i | input | 1 | Demand access present |
| dm_addr_i | input | 32 | Demand byte address |
| dm_hit_o | output | 1 | Demand access hits (same cycle) |
| dm_miss_o | output | 1 | Demand access misses (same cycle) |
| fill_valid_i | input | 1 | Line fill present |
| fill_is_pf_i | input | 1 | 1: prefetch fill, 0: demand-miss fill |
| fill_addr_i | input | 32 | Fill byte address |
| fill_pc_i | input | 32 | Trigger PC of a prefetch fill |
| ev_valid_o | output | 1 | Eviction record pulse |
| ev_addr_o | output | 32 | Line address of the evicted prefetched line |
| ev_pc_o | output | 32 | Trigger PC stored with the evicted line |
| ev_good_o | output | 1 | 1 if the evicted prefetched line was used |

## Verification
Some faults show up at once. A wrong valid bit or a corrupted tag makes the hit/miss answer wrong in the same cycle as the next demand access to that index.

Faults in the prefetch mark, the reference mark or the stored PC are silent until the line is replaced. They then appear one cycle after the fill edge, as a missing or spurious record, a wrong verdict or a wrong PC. For this reason the bench replaces every line it marks, including same-cycle hit-and-replace and same-tag refills, and compares the outputs against a reference model on every cycle.

// File: rtl/pf_tag_pkg.sv
package pf_tag_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_PC_W       = 32;
  localparam int unsigned DEF_NUM_LINES  = 256;
  localparam int unsigned DEF_LINE_BYTES = 32;

  typedef enum logic {
    FILL_DEMAND   = 1'b0,
    FILL_PREFETCH = 1'b1
  } fill_kind_e;
endpackage

// File: rtl/pf_line_flags.sv
// Per-line valid / prefetch / reference state with async clear.
module pf_line_flags #(
  parameter int unsigned NUM_LINES = 256,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_pf_i,
  input  logic             ref_en_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_valid_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic             rd_b_valid_o,
  output logic             rd_b_pf_o,
  output logic             rd_b_ref_o
);
  logic [NUM_LINES-1:0] valid_q, pf_q, ref_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic wr_hit, ref_hit;
    assign wr_hit  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    assign ref_hit = ref_en_i && (ref_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        pf_q[g]    <= 1'b0;
        ref_q[g]   <= 1'b0;
      end else if (wr_hit) begin
        valid_q[g] <= 1'b1;
        pf_q[g]    <= wr_pf_i;
        ref_q[g]   <= 1'b0;
      end else if (ref_hit) begin
        ref_q[g]   <= 1'b1;
      end
    end
  end

  assign rd_a_valid_o = valid_q[rd_a_idx_i];
  assign rd_b_valid_o = valid_q[rd_b_idx_i];
  assign rd_b_pf_o    = pf_q[rd_b_idx_i];
  assign rd_b_ref_o   = ref_q[rd_b_idx_i];
endmodule

// File: rtl/pf_tag_ram.sv
// Tag and trigger-PC storage; no reset needed, gated by valid.
module pf_tag_ram #(
  parameter int unsigned NUM_LINES = 256,
  parameter int unsigned TAG_W     = 19,
  parameter int unsigned PC_W      = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic             wr_pc_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [TAG_W-1:0] rd_a_tag_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [TAG_W-1:0] rd_b_tag_o,
  output logic [PC_W-1:0]  rd_b_pc_o
);
  logic [TAG_W-1:0] tag_mem [NUM_LINES];
  logic [PC_W-1:0]  pc_mem  [NUM_LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_mem[wr_idx_i] <= wr_tag_i;
    if (wr_en_i && wr_pc_en_i) pc_mem[wr_idx_i] <= wr_pc_i;
  end

  assign rd_a_tag_o = tag_mem[rd_a_idx_i];
  assign rd_b_tag_o = tag_mem[rd_b_idx_i];
  assign rd_b_pc_o  = pc_mem[rd_b_idx_i];
endmodule

// File: rtl/pf_evict_reg.sv
// Registers the eviction record; one-cycle pulse.
module pf_evict_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              good_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              good_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      pc_o    <= '0;
      good_o  <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        addr_o <= addr_i;
        pc_o   <= pc_i;
        good_o <= good_i;
      end
    end
  end
endmodule

// File: rtl/pf_tag_store.sv
module pf_tag_store
  import pf_tag_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned PC_W       = DEF_PC_W,
  parameter int unsigned NUM_LINES  = DEF_NUM_LINES,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dm_valid_i,
  input  logic [ADDR_W-1:0] dm_addr_i,
  output logic              dm_hit_o,
  output logic              dm_miss_o,
  input  logic              fill_valid_i,
  input  logic              fill_is_pf_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [PC_W-1:0]   fill_pc_i,
  output logic              ev_valid_o,
  output logic [ADDR_W-1:0] ev_addr_o,
  output logic [PC_W-1:0]   ev_pc_o,
  output logic              ev_good_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  fill_kind_e       fill_kind;
  logic [IDX_W-1:0] dm_idx, fl_idx;
  logic [TAG_W-1:0] dm_tag, fl_tag;
  logic [TAG_W-1:0] dm_tag_q, fl_tag_q;
  logic [PC_W-1:0]  fl_pc_q;
  logic             dm_line_v, fl_line_v, fl_line_pf, fl_line_ref;
  logic             fl_same_tag, fl_write, fl_record, ref_set;
  logic             unused_off;

  assign fill_kind = fill_kind_e'(fill_is_pf_i);
  assign dm_idx    = dm_addr_i[OFF_W +: IDX_W];
  assign dm_tag    = dm_addr_i[ADDR_W-1 -: TAG_W];
  assign fl_idx    = fill_addr_i[OFF_W +: IDX_W];
  assign fl_tag    = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{dm_addr_i[OFF_W-1:0], fill_addr_i[OFF_W-1:0]};

  pf_line_flags #(.NUM_LINES(NUM_LINES)) i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (fl_write),
    .wr_idx_i     (fl_idx),
    .wr_pf_i      (fill_kind == FILL_PREFETCH),
    .ref_en_i     (ref_set),
    .ref_idx_i    (dm_idx),
    .rd_a_idx_i   (dm_idx),
    .rd_a_valid_o (dm_line_v),
    .rd_b_idx_i   (fl_idx),
    .rd_b_valid_o (fl_line_v),
    .rd_b_pf_o    (fl_line_pf),
    .rd_b_ref_o   (fl_line_ref)
  );

  pf_tag_ram #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .PC_W(PC_W)) i_ram (
    .clk_i      (clk_i),
    .wr_en_i    (fl_write),
    .wr_pc_en_i (fill_kind == FILL_PREFETCH),
    .wr_idx_i   (fl_idx),
    .wr_tag_i   (fl_tag),
    .wr_pc_i    (fill_pc_i),
    .rd_a_idx_i (dm_idx),
    .rd_a_tag_o (dm_tag_q),
    .rd_b_idx_i (fl_idx),
    .rd_b_tag_o (fl_tag_q),
    .rd_b_pc_o  (fl_pc_q)
  );

  // Demand lookup, same cycle.
  assign dm_hit_o  = dm_valid_i && dm_line_v && (dm_tag_q == dm_tag);
  assign dm_miss_o = dm_valid_i && !dm_hit_o;

  // A prefetch to a resident line is dropped; every other fill writes.
  assign fl_same_tag = fl_line_v && (fl_tag_q == fl_tag);
  assign fl_write    = fill_valid_i && !(fill_kind == FILL_PREFETCH && fl_same_tag);
  assign fl_record   = fl_write && fl_line_v && fl_line_pf && !fl_same_tag;
  // The hit's reference mark is lost if the same line is rewritten now.
  assign ref_set     = dm_hit_o && !(fl_write && (fl_idx == dm_idx));

  pf_evict_reg #(.ADDR_W(ADDR_W), .PC_W(PC_W)) i_ev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fl_record),
    .addr_i  ({fl_tag_q, fl_idx, {OFF_W{1'b0}}}),
    .pc_i    (fl_pc_q),
    .good_i  (fl_line_ref || (dm_hit_o && (dm_idx == fl_idx))),
    .valid_o (ev_valid_o),
    .addr_o  (ev_addr_o),
    .pc_o    (ev_pc_o),
    .good_o  (ev_good_o)
  );
endmodule

// File: rtl/pf_tag_store_chk.sv
module pf_tag_store_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned NUM_LINES  = 256,
  parameter int unsigned LINE_BYTES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dm_valid_i,
  input logic [ADDR_W-1:0] dm_addr_i,
  input logic              dm_hit_o,
  input logic              dm_miss_o,
  input logic              fill_valid_i,
  input logic              fill_is_pf_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic [PC_W-1:0]   fill_pc_i,
  input logic              ev_valid_o,
  input logic [ADDR_W-1:0] ev_addr_o,
  input logic [PC_W-1:0]   ev_pc_o,
  input logic              ev_good_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  logic unused_chk;
  assign unused_chk = ^{fill_is_pf_i, fill_pc_i, ev_pc_o, ev_good_o};

  // R1: hit and miss never together
  a_r1_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dm_hit_o && dm_miss_o));
  // R1: no answer without a request
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_valid_i |-> !dm_hit_o && !dm_miss_o);
  // R1: every request gets exactly one answer
  a_r1_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_valid_i |-> $countones({dm_hit_o, dm_miss_o}) == 1);
  // R10: record only after a fill edge
  a_r10_ev_needs_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_valid_i) |=> !ev_valid_o);
  // R6: record address is line aligned
  a_r6_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> ev_addr_o[OFF_W-1:0] == '0);
  // R8: fill of a line that is hit on the same tag evicts nothing
  a_r8_resident_no_ev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && dm_hit_o &&
     fill_addr_i[ADDR_W-1:OFF_W] == dm_addr_i[ADDR_W-1:OFF_W]) |=> !ev_valid_o);
endmodule

bind pf_tag_store pf_tag_store_chk #(
  .ADDR_W(ADDR_W), .PC_W(PC_W), .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES)
) i_pf_tag_store_chk (.*);

// File: tb/test_pf_tag_store.sv
`timescale 1ns/1ps
module test_pf_tag_store;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dm_valid_i = 1'b0;
  logic [31:0] dm_addr_i = '0;
  logic        dm_hit_o, dm_miss_o;
  logic        fill_valid_i = 1'b0;
  logic        fill_is_pf_i = 1'b0;
  logic [31:0] fill_addr_i = '0;
  logic [31:0] fill_pc_i = '0;
  logic        ev_valid_o, ev_good_o;
  logic [31:0] ev_addr_o, ev_pc_o;

  always #4 clk_i = ~clk_i;

  pf_tag_store i_pf_tag_store (.*);

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model
  bit          mv   [256];
  bit          mpf  [256];
  bit          mref [256];
  int unsigned mtag [256];
  bit [31:0]   mpc  [256];
  bit          x_ev_v = 0, x_ev_g = 0;
  bit [31:0]   x_ev_a = 0, x_ev_p = 0;

  function automatic bit [31:0] mk(int unsigned tag, int unsigned idx);
    return {tag[18:0], idx[7:0], 5'b0};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin mv[i] = 0; mpf[i] = 0; mref[i] = 0; end
    x_ev_v = 0;
  endtask

  // one cycle: inputs driven after negedge, outputs sampled before the edge
  task automatic step(string req, bit dv, bit [31:0] da, bit fv, bit fpf,
                      bit [31:0] fa, bit [31:0] fpc);
    int unsigned di, dt, fi, ft;
    bit hit, wr;
    chk(req, "ev_valid", ev_valid_o, 32'(x_ev_v));
    if (x_ev_v) begin
      chk(req, "ev_addr", ev_addr_o, x_ev_a);
      chk(req, "ev_pc", ev_pc_o, x_ev_p);
      chk(req, "ev_good", ev_good_o, 32'(x_ev_g));
    end
    dm_valid_i = dv; dm_addr_i = da;
    fill_valid_i = fv; fill_is_pf_i = fpf; fill_addr_i = fa; fill_pc_i = fpc;
    #1;
    di = da[12:5]; dt = da[31:13]; fi = fa[12:5]; ft = fa[31:13];
    hit = dv && mv[di] && mtag[di] == dt;
    chk(req, "dm_hit", dm_hit_o, 32'(hit));
    chk(req, "dm_miss", dm_miss_o, 32'(dv && !hit));
    wr = fv && !(fpf && mv[fi] && mtag[fi] == ft);
    x_ev_v = wr && mv[fi] && mpf[fi] && mtag[fi] != ft;
    if (x_ev_v) begin
      x_ev_a = mk(mtag[fi], fi);
      x_ev_p = mpc[fi];
      x_ev_g = mref[fi] || (hit && di == fi);
    end
    if (hit && !(wr && fi == di)) mref[di] = 1;
    if (wr) begin
      mv[fi] = 1; mtag[fi] = ft; mpf[fi] = fpf; mref[fi] = 0;
      if (fpf) mpc[fi] = fpc;
    end
    @(negedge clk_i);
  endtask

  task automatic dm(string req, bit [31:0] a);
    step(req, 1, a, 0, 0, 0, 0);
  endtask
  task automatic fill(string req, bit pf, bit [31:0] a, bit [31:0] pc);
    step(req, 0, 0, 1, pf, a, pc);
  endtask
  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    chk("R2", "ev_valid in reset", ev_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: empty after reset
    dm("R2", mk(1, 3));
    dm("R2", mk(0, 0));
    // R3: demand fill, hit, then displaced silently
    fill("R3", 0, mk(1, 3), 0);
    dm("R1", mk(1, 3));
    dm("R1", mk(2, 3));
    fill("R3", 1, mk(2, 3), 32'h1111_0000);
    idle("R3");
    // R4/R6: unused prefetch displaced -> bad record
    fill("R4", 1, mk(7, 5), 32'hA000_0004);
    fill("R6", 1, mk(9, 5), 32'hA000_0008);
    idle("R6");
    idle("R10");
    // R5: used prefetch displaced by demand fill -> good
    fill("R4", 1, mk(1, 6), 32'hB000_0010);
    dm("R5", mk(1, 6) + 32'h1c);
    fill("R6", 0, mk(2, 6), 0);
    idle("R6");
    // R8: repeated prefetch to resident line ignored, keeps mark and PC
    fill("R4", 1, mk(1, 7), 32'hC000_0000);
    dm("R5", mk(1, 7));
    fill("R8", 1, mk(1, 7), 32'hD000_0000);
    fill("R8", 0, mk(4, 7), 0);
    idle("R8");
    // R9: same-cycle hit and replace
    fill("R4", 1, mk(1, 8), 32'hE000_0000);
    step("R9", 1, mk(1, 8), 1, 1, mk(3, 8), 32'hE000_0100);
    fill("R9", 1, mk(4, 8), 32'hE000_0200);
    idle("R9");
    // R7: demand refill of same tag clears marks, no record
    fill("R4", 1, mk(1, 9), 32'hF000_0000);
    fill("R7", 0, mk(1, 9), 0);
    fill("R7", 1, mk(2, 9), 32'hF000_0004);
    idle("R7");
    // boundary indices and widest tag
    fill("R4", 1, mk(32'h7FFFF, 255), 32'hFFFF_FFFC);
    fill("R4", 1, mk(0, 0), 32'h0000_0004);
    fill("R6", 1, mk(1, 255), 0);
    fill("R6", 0, mk(32'h7FFFF, 0), 0);
    dm("R1", mk(32'h7FFFF, 0));
    idle("R10");
    // mixed traffic, small tag range to force conflicts
    for (int n = 0; n < 2000; n++) begin
      bit [31:0] ra, rb, rp;
      ra = mk($urandom_range(0, 3), $urandom_range(0, 15)) | $urandom_range(0, 31);
      rb = mk($urandom_range(0, 3), $urandom_range(0, 15));
      rp = $urandom;
      step("R1/R6", 1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), rb, rp);
    end
    idle("R10");
    // R2: reset mid-run clears everything
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    dm("R2", mk(2, 6));
    dm("R2", mk(32'h7FFFF, 0));
    idle("R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule